// File: doc/BRIEF.md
# DRAM Cycle Decoder with Parallel Test Mode

This block is the device-side control logic of a one-bit-wide asynchronous DRAM, modelled as synchronous logic. A fast system clock samples the four active-low strobes (row strobe, column strobe, write enable, output enable). The block compares each strobe with its value from the previous clock to find its edges. From the order of those edges it decides what kind of cycle is running:
- refresh with the row strobe only;
- refresh with the column strobe falling before the row strobe;
- test-mode entry;
- normal read;
- early write;
- read-modify-write.

After reset the block counts refresh cycles. It accepts no reads or writes until enough refresh cycles have been seen. A latched test mode groups four cells and changes how reads and writes work. A test read returns one pass/fail bit that says whether the four cells agree, and it arrives one clock later than a normal read. A test write stores the input bit into all four cells. The storage is a small parameterized register array. The row and column address widths are cut down for simulation.

A surrounding model or test environment uses the block by driving the strobes and the multiplexed address the way a memory controller would. It then watches the data-out value and its enable.

Top module: `dram_ctl_decoder`

## Requirements
- R1: After reset, read and write cycles are ignored until INIT_CYCLES (default 8) refresh cycles have completed. While ignored, dout_en stays 0 and the array is not changed. Only row-only refreshes and column-before-row refreshes count.
- R2: If both we_n and cas_n are low when ras_n falls, test mode is set. It stays set over later cycles. Such an entry cycle does not count toward R1.
- R3: Test mode is cleared by a row-only refresh (ras_n falls and rises with no cas_n fall in between). It is also cleared by a column-before-row refresh with we_n high. After it is cleared, reads use normal latency and single-cell data.
- R4: A normal read drives dout_en=1 and dout = the addressed cell. This happens after the second rising clock edge that sees cas_n low. dout_en is 0 after the first such edge.
- R5: In test mode, a read returns 1 when the four cells of the group hold equal values and 0 when any one differs. The group is every cell whose row matches with row bit ROW_W-1 ignored and whose column matches with column bit 0 ignored.
- R6: In test mode, a write stores din into all four cells of the selected group.
- R7: If we_n is already low when cas_n falls, the cycle is an early write. din is stored in the addressed cell and dout_en stays 0 for the whole cycle.
- R8: In a read where we_n falls after the data is out, dout keeps the value read before the write. din is stored in the cell, and a later read returns it.
- R9: dout_en is 0 whenever oe_n, cas_n or ras_n is high. When dout_en is 0, dout is 0.
- R10: The row address is taken on the clock that sees ras_n fall, and the column address on the clock that sees cas_n fall. Later address changes in the same cycle have no effect.
- R11: A test-mode read drives dout_en one clock later than a normal read, that is, after the third rising edge that sees cas_n low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 1 | Write data |
| dout | output | 1 | Read data, or test pass/fail bit |
| dout_en | output | 1 | Data-out drive enable (0 = high impedance) |

## Verification
The assertions check, on every cycle, the rules that link one event to the next:
- the test-mode flag is set by an entry cycle, cleared by a refresh, and held otherwise;
- the initialization flag never drops;
- the output is never enabled before initialization ends or on the edge right after the column strobe falls;
- an early write never enables the output;
- a read-modify-write holds the presented data.

Only the bench scenarios can show the values stored in the array. These include the group compare with its ignored address bits, the four-cell write in test mode, and the old-then-new data of a read-modify-write. The bench scenarios also show which cycles count toward initialization and the exact latency difference between the two modes.

// File: rtl/dram_dec_pkg.sv
`timescale 1ns/1ps
package dram_dec_pkg;
   // Phase of the current row-strobe cycle
   typedef enum logic [1:0] {
      CY_IDLE    = 2'd0,   // row strobe high
      CY_ROWOPEN = 2'd1,   // row strobe fell with column strobe high
      CY_CBR     = 2'd2,   // row strobe fell with column strobe already low
      CY_ACCESS  = 2'd3    // column strobe fell inside an open row
   } cyc_t;

   localparam int GROUP_CELLS = 4;
endpackage

// File: rtl/dram_pin_edges.sv
`timescale 1ns/1ps
module dram_pin_edges #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pins_n,
   output logic [N-1:0] fall,
   output logic [N-1:0] rise
);
   if (N < 1) begin : g_bad_n
      $error("dram_pin_edges: N must be at least 1");
   end

   logic [N-1:0] prev_q;

   // strobes idle high, so reset to 1 to avoid a false edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= pins_n;
   end

   assign fall = prev_q & ~pins_n;
   assign rise = ~prev_q & pins_n;
endmodule

// File: rtl/dram_mode_ctl.sv
`timescale 1ns/1ps
module dram_mode_ctl #(
   parameter int INIT_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ev_refresh,
   input  logic ev_tentry,
   output logic init_done,
   output logic test_mode
);
   localparam int CW = $clog2(INIT_CYCLES + 1);

   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("dram_mode_ctl: INIT_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   assign init_done = (cnt_q == CW'(INIT_CYCLES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         test_mode <= 1'b0;
      end else begin
         if (ev_refresh && !init_done) cnt_q <= cnt_q + 1'b1;
         if (ev_tentry)       test_mode <= 1'b1;
         else if (ev_refresh) test_mode <= 1'b0;
      end
   end

   // R2
   tm_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tentry |=> test_mode);
   // R3
   tm_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_refresh |=> !test_mode);
   // R3
   tm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_tentry && !ev_refresh) |=> $stable(test_mode));
   // R1
   init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);
endmodule

// File: rtl/dram_cell_array.sv
`timescale 1ns/1ps
module dram_cell_array #(
   parameter int ROW_W        = 4,
   parameter int COL_W        = 3,
   parameter int TEST_ROW_BIT = ROW_W - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             grp_mode,
   input  logic [ROW_W-1:0] wr_row,
   input  logic [COL_W-1:0] wr_col,
   input  logic             wr_bit,
   input  logic [ROW_W-1:0] rd_row,
   input  logic [COL_W-1:0] rd_col,
   output logic             rd_val
);
   localparam int COLS  = 1 << COL_W;
   localparam int CELLS = (1 << ROW_W) * COLS;
   localparam logic [ROW_W-1:0] RMASK = ROW_W'(1) << TEST_ROW_BIT;
   localparam logic [COL_W-1:0] CMASK = COL_W'(1);

   if (TEST_ROW_BIT >= ROW_W || TEST_ROW_BIT < 0) begin : g_bad_trow
      $error("dram_cell_array: TEST_ROW_BIT outside the row address");
   end
   if (COL_W < 1) begin : g_bad_col
      $error("dram_cell_array: COL_W must be at least 1");
   end

   logic [CELLS-1:0] cells;

   for (genvar gi = 0; gi < CELLS; gi++) begin : g_cell
      localparam logic [ROW_W-1:0] CR = ROW_W'(gi / COLS);
      localparam logic [COL_W-1:0] CC = COL_W'(gi % COLS);
      logic hit;
      logic bit_q;
      assign hit = grp_mode ?
                   (((CR | RMASK) == (wr_row | RMASK)) && ((CC | CMASK) == (wr_col | CMASK))) :
                   ((CR == wr_row) && (CC == wr_col));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             bit_q <= 1'b0;
         else if (wr_en && hit)  bit_q <= wr_bit;
      end
      assign cells[gi] = bit_q;
   end

   logic [ROW_W-1:0] r_lo, r_hi;
   logic [COL_W-1:0] c_lo, c_hi;
   logic [dram_dec_pkg::GROUP_CELLS-1:0] grp_bits;

   assign r_lo = rd_row & ~RMASK;
   assign r_hi = rd_row | RMASK;
   assign c_lo = rd_col & ~CMASK;
   assign c_hi = rd_col | CMASK;
   assign grp_bits = {cells[{r_hi, c_hi}], cells[{r_hi, c_lo}],
                      cells[{r_lo, c_hi}], cells[{r_lo, c_lo}]};

   assign rd_val = grp_mode ? ((&grp_bits) | ~(|grp_bits)) : cells[{rd_row, rd_col}];
endmodule

// File: rtl/dram_ctl_decoder.sv
`timescale 1ns/1ps
module dram_ctl_decoder
   import dram_dec_pkg::*;
#(
   parameter int ROW_W        = 4,
   parameter int COL_W        = 3,
   parameter int INIT_CYCLES  = 8,
   parameter int TEST_ROW_BIT = ROW_W - 1,
   parameter int ADDR_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              din,
   output logic              dout,
   output logic              dout_en
);
   if (ADDR_W < ROW_W || ADDR_W < COL_W) begin : g_bad_addr
      $error("dram_ctl_decoder: ADDR_W narrower than row or column");
   end

   logic [2:0] fall, rise;
   dram_pin_edges #(.N(3)) u_edges (
      .clk(clk), .rst_n(rst_n), .pins_n({ras_n, cas_n, we_n}),
      .fall(fall), .rise(rise)
   );

   logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
   assign ras_fall = fall[2];
   assign ras_rise = rise[2];
   assign cas_fall = fall[1];
   assign cas_rise = rise[1];
   assign we_fall  = fall[0];
   logic unused_we_rise;
   assign unused_we_rise = rise[0];

   cyc_t             cyc_q;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;
   logic             rd_act, rd_bit;
   logic [1:0]       lat_q;
   logic             init_done, test_mode, rd_val;

   logic acc_start, ev_cbr, ev_tentry, ev_ror, ev_refresh;
   logic early_wr, rmw_wr, wr_en;
   logic [COL_W-1:0] wr_col;

   assign acc_start  = cas_fall && !ras_n && (cyc_q == CY_ROWOPEN);
   assign ev_cbr     = ras_fall && !cas_n && we_n;
   assign ev_tentry  = ras_fall && !cas_n && !we_n;
   assign ev_ror     = ras_rise && (cyc_q == CY_ROWOPEN);
   assign ev_refresh = ev_cbr || ev_ror;
   assign early_wr   = acc_start && !we_n && init_done;
   assign rmw_wr     = we_fall && !cas_n && !ras_n && rd_act && init_done;
   assign wr_en      = early_wr || rmw_wr;
   assign wr_col     = acc_start ? addr[COL_W-1:0] : col_q;

   dram_mode_ctl #(.INIT_CYCLES(INIT_CYCLES)) u_mode (
      .clk(clk), .rst_n(rst_n), .ev_refresh(ev_refresh), .ev_tentry(ev_tentry),
      .init_done(init_done), .test_mode(test_mode)
   );

   dram_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W), .TEST_ROW_BIT(TEST_ROW_BIT)) u_array (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .grp_mode(test_mode),
      .wr_row(row_q), .wr_col(wr_col), .wr_bit(din),
      .rd_row(row_q), .rd_col(col_q), .rd_val(rd_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q  <= CY_IDLE;
         row_q  <= '0;
         col_q  <= '0;
         rd_act <= 1'b0;
         lat_q  <= '0;
         rd_bit <= 1'b0;
      end else begin
         if (ras_fall) begin
            row_q <= addr[ROW_W-1:0];
            cyc_q <= cas_n ? CY_ROWOPEN : CY_CBR;
         end else if (ras_rise) begin
            cyc_q <= CY_IDLE;
         end else if (acc_start) begin
            cyc_q <= CY_ACCESS;
         end
         if (acc_start) col_q <= addr[COL_W-1:0];
         if (ras_rise || cas_rise) begin
            rd_act <= 1'b0;
            lat_q  <= '0;
         end else if (acc_start && we_n && init_done) begin
            rd_act <= 1'b1;
            lat_q  <= test_mode ? 2'd2 : 2'd1;
         end else if (rd_act && lat_q != 2'd0) begin
            lat_q <= lat_q - 2'd1;
            if (lat_q == 2'd1) rd_bit <= rd_val;
         end
      end
   end

   assign dout_en = rd_act && (lat_q == 2'd0) && !oe_n && !cas_n && !ras_n;
   assign dout    = dout_en ? rd_bit : 1'b0;

   // R1
   out_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout_en |-> init_done);
   // R4
   no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_start |=> !dout_en);
   // R7
   early_wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_start && !we_n) |=> ##1 !dout_en);
   // R8
   rmw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rmw_wr && dout_en) |=> (!dout_en || dout == $past(dout)));
endmodule

// File: tb/dram_ctl_decoder_tb.sv
`timescale 1ns/1ps
module dram_ctl_decoder_tb;
   localparam int ROW_W = 4;
   localparam int COL_W = 3;
   localparam int AW    = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic din = 1'b0;
   logic dout, dout_en;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   dram_ctl_decoder #(.ROW_W(ROW_W), .COL_W(COL_W), .INIT_CYCLES(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic do_ror(input int row);
      addr = AW'(row); ras_n = 1'b0;
      tick(); tick();
      ras_n = 1'b1;
      tick(); tick();
   endtask

   task automatic do_cbr(input bit we);
      cas_n = 1'b0; we_n = we;
      tick();
      ras_n = 1'b0;
      tick(); tick();
      idle();
      tick(); tick();
   endtask

   task automatic do_write(input int row, input int col, input bit b);
      addr = AW'(row); ras_n = 1'b0;
      tick();
      addr = AW'(col); din = b; we_n = 1'b0; cas_n = 1'b0; oe_n = 1'b0;
      tick();
      chk(dout_en == 1'b0, "R7 early write edge", int'(dout_en), 0);
      tick();
      chk(dout_en == 1'b0, "R7 early write hold", int'(dout_en), 0);
      tick();
      chk(dout_en == 1'b0, "R7 early write late", int'(dout_en), 0);
      idle();
      tick(); tick();
   endtask

   task automatic do_read(input int row, input int col, input bit tst, input bit exp,
                          input string req);
      addr = AW'(row); ras_n = 1'b0;
      tick();
      addr = AW'(col); cas_n = 1'b0; oe_n = 1'b0;
      tick();
      addr = ~AW'(col);   // R10: later address change must not matter
      chk(dout_en == 1'b0, "R4 no output after first edge", int'(dout_en), 0);
      tick();
      if (tst) begin
         chk(dout_en == 1'b0, "R11 test read one clock later", int'(dout_en), 0);
         tick();
      end
      chk(dout_en == 1'b1, {req, " enable"}, int'(dout_en), 1);
      chk(dout == exp, {req, " data"}, int'(dout), int'(exp));
      oe_n = 1'b1; #1;
      chk(dout_en == 1'b0 && dout == 1'b0, "R9 oe high", int'(dout_en), 0);
      oe_n = 1'b0; #1;
      chk(dout_en == 1'b1, "R9 oe low again", int'(dout_en), 1);
      cas_n = 1'b1; #1;
      chk(dout_en == 1'b0, "R9 cas high", int'(dout_en), 0);
      idle();
      tick(); tick();
   endtask

   task automatic do_read_blocked(input int row, input int col, input string req);
      addr = AW'(row); ras_n = 1'b0;
      tick();
      addr = AW'(col); cas_n = 1'b0; oe_n = 1'b0;
      tick(); tick(); tick();
      chk(dout_en == 1'b0, req, int'(dout_en), 0);
      idle();
      tick(); tick();
   endtask

   task automatic do_rmw(input int row, input int col, input bit old_b, input bit new_b);
      addr = AW'(row); ras_n = 1'b0;
      tick();
      addr = AW'(col); cas_n = 1'b0; oe_n = 1'b0;
      tick(); tick();
      chk(dout_en == 1'b1 && dout == old_b, "R8 read phase", int'(dout), int'(old_b));
      din = new_b; we_n = 1'b0;
      tick();
      chk(dout_en == 1'b1 && dout == old_b, "R8 data held at write", int'(dout), int'(old_b));
      tick();
      chk(dout == old_b, "R8 data held after write", int'(dout), int'(old_b));
      idle();
      tick(); tick();
   endtask

   task automatic t_reset();
      idle();
      rst_n = 1'b0;
      tick(); tick();
      chk(dout_en == 1'b0 && dout == 1'b0, "R1 reset state", int'(dout_en), 0);
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_init();
      do_write(1, 2, 1'b1);                      // R1: ignored before init
      do_read_blocked(1, 2, "R1 read blocked before init");
      for (int i = 0; i < 4; i++) do_ror(i);
      for (int i = 0; i < 3; i++) do_cbr(1'b1);
      do_cbr(1'b0);                              // R2: entry, does not count
      do_read_blocked(1, 2, "R2 entry not counted as init");
      do_ror(9);                                 // 8th refresh, also exits test mode
      do_read(1, 2, 1'b0, 1'b0, "R1 write before init ignored / R3 normal after exit");
   endtask

   task automatic t_normal();
      do_write(1, 2, 1'b1);
      do_write(5, 7, 1'b1);
      do_read(1, 2, 1'b0, 1'b1, "R4 read 1,2");
      do_read(5, 7, 1'b0, 1'b1, "R4 read 5,7");
      do_read(5, 6, 1'b0, 1'b0, "R10 read 5,6 untouched");
      do_write(1, 2, 1'b0);
      do_read(1, 2, 1'b0, 1'b0, "R7 early write stored 0");
   endtask

   task automatic t_rmw();
      do_rmw(5, 7, 1'b1, 1'b0);
      do_read(5, 7, 1'b0, 1'b0, "R8 new data stored");
   endtask

   task automatic t_test_mode();
      do_write(2, 4, 1'b1);                      // group {2,10}x{4,5}: one cell set
      do_cbr(1'b0);                              // R2 enter
      do_read(10, 5, 1'b1, 1'b0, "R5 mismatch gives 0");
      do_read(0, 0, 1'b1, 1'b1, "R5 all-zero group gives 1");
      do_write(2, 4, 1'b1);                      // R6 group write
      do_read(10, 4, 1'b1, 1'b1, "R6 group write then compare 1");
      do_read(2, 5, 1'b1, 1'b1, "R2 test mode persists");
      do_cbr(1'b1);                              // R3 exit by column-before-row
      do_read(10, 5, 1'b0, 1'b1, "R6 fourth cell written, R3 normal latency");
      do_read(10, 6, 1'b0, 1'b0, "R6 neighbour group untouched");
      do_cbr(1'b0);
      do_ror(3);                                 // R3 exit by row-only
      do_read(2, 5, 1'b0, 1'b1, "R3 row-only exit normal read");
   endtask

   initial begin
      t_reset();
      t_init();
      t_normal();
      t_rmw();
      t_test_mode();
      report();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      report();
   end
endmodule